// File: doc/BRIEF.md
# Performance Event Counter Bank with Overflow Interrupt

This block keeps a bank of free-running 32-bit event counters. Each counter has one event input. A counter advances by one on a cycle where its event pulses, its own enable is set and the bank-wide enable is on. When a counter steps past its all-ones value it wraps to zero and raises a sticky overflow flag. Each counter also has an interrupt enable. A single interrupt line is raised while any flagged counter has its interrupt enabled.

Software reaches the block through one write port and one combinational read port. The map holds:
- a control word with a run bit and a self-clearing bank-zero bit;
- separate set and clear addresses for the counter enables and for the interrupt enables;
- a write-one-to-clear overflow word;
- one word per counter.

The main guarantee is that no overflow is dropped when it coincides with a register write. This holds for writes to the control, enable, interrupt-enable and overflow-status words, and for writes to addresses outside the map that share the port.

Top module: `pmu_ovf_unit`

## Requirements
- R1: Counter i increments by one at a clock edge when event_i[i] is high, counter enable bit i is 1 and control bit 0 (run) is 1, and holds its value otherwise.
- R2: A counter at 0xFFFF_FFFF that increments becomes 0 and sets bit i of the overflow word (word address 5).
- R3: irq is a register that equals, one cycle later, the OR over all counters of (overflow bit AND interrupt-enable bit), so it stays high until every contributing flag is cleared or disabled.
- R4: An overflow is recorded and reaches irq even when, in the same cycle, the port writes any non-counter address: control (0), enable set/clear (1/2), interrupt-enable set/clear (3/4), overflow word (5), or any unmapped address.
- R5: Writing 1 to bit i of the overflow word clears it. Writing 0 leaves it unchanged. If counter i overflows in the same cycle that its bit is being cleared, the bit stays set.
- R6: Writing 1 to bit i at address 1 or 3 sets counter enable i or interrupt enable i. Writing 1 at address 2 or 4 clears it. Zero bits have no effect. Addresses 1 and 2 both read the enable mask, and addresses 3 and 4 both read the interrupt-enable mask.
- R7: A write to counter i (word address 8+i) loads that value and overrides the same cycle's increment. An overflow that this increment would have produced is not recorded.
- R8: Writing control with bit 1 set clears every counter to zero at that edge and leaves the overflow flags unchanged. Bit 1 always reads as 0.
- R9: After reset all counters, enables, flags and the run bit are 0 and irq is low.
- R10: Unmapped addresses (6, 7 and 8+NUM_CTR upward) read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | NUM_CTR | Per-counter event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Registered overflow interrupt level |

## Verification
The case that matters is a counter wrapping past all-ones on the same edge that the write port targets a control, enable, status or unmapped address. The bench forces this collision by preloading a counter to 0xFFFF_FFFF. It then pulses that counter's event together with a write to each such address in turn, including a clear of the same overflow bit and a bank-zero command. It then reads the overflow word and samples irq one cycle later. A random phase with preloads near all-ones keeps producing these collisions, and a behavioural model checks every register and irq on every clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    // Word addresses of the non-counter registers
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET = 6'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 6'd2;
    localparam logic [ADDR_W-1:0] A_IE_SET = 6'd3;
    localparam logic [ADDR_W-1:0] A_IE_CLR = 6'd4;
    localparam logic [ADDR_W-1:0] A_OVF    = 6'd5;

    // First counter word; counter i sits at CNT_BASE + i
    localparam int CNT_BASE = 8;

    // Control word fields
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_ZERO_BIT = 1;

    // One strobe per non-counter register
    typedef struct packed {
        logic ctrl;
        logic en_set;
        logic en_clr;
        logic ie_set;
        logic ie_clr;
        logic ovf_clr;
    } ctl_wr_t;

    function automatic logic [ADDR_W-1:0] ctr_addr(input int idx);
        return ADDR_W'(CNT_BASE + idx);
    endfunction

endpackage

// File: rtl/pmu_wr_decode.sv
module pmu_wr_decode
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output ctl_wr_t           strb,
    output logic [NUM_CTR-1:0] ctr_hit
);

    always_comb begin
        strb         = '0;
        strb.ctrl    = wr_en && (wr_addr == A_CTRL);
        strb.en_set  = wr_en && (wr_addr == A_EN_SET);
        strb.en_clr  = wr_en && (wr_addr == A_EN_CLR);
        strb.ie_set  = wr_en && (wr_addr == A_IE_SET);
        strb.ie_clr  = wr_en && (wr_addr == A_IE_CLR);
        strb.ovf_clr = wr_en && (wr_addr == A_OVF);
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_hit
        assign ctr_hit[i] = wr_en && (wr_addr == ctr_addr(i));
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr_hit,
    input  logic         clr_all,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf_evt
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         at_max;

    assign at_max = &cnt_q;

    always_comb begin
        ovf_evt = inc && at_max && !wr_hit;
        if (wr_hit)       cnt_d = wdata;
        else if (clr_all) cnt_d = '0;
        else if (inc)     cnt_d = cnt_q + W'(1);
        else              cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R1
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_hit && !clr_all) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> (cnt_q == '0));

    // R7
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (cnt_q == $past(wdata)));

    // R8
    bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_hit) |=> (cnt_q == '0));

endmodule

// File: rtl/pmu_flags.sv
module pmu_flags
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_wr_t            strb,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CTR-1:0] ovf_evt,
    output logic               run,
    output logic               clr_all,
    output logic [NUM_CTR-1:0] en,
    output logic [NUM_CTR-1:0] ie,
    output logic [NUM_CTR-1:0] ovf,
    output logic               irq
);

    logic [NUM_CTR-1:0] mask;
    logic [NUM_CTR-1:0] en_q, en_d;
    logic [NUM_CTR-1:0] ie_q, ie_d;
    logic [NUM_CTR-1:0] ovf_q, ovf_d;
    logic               run_q, run_d;
    logic               irq_q;

    assign mask    = wdata[NUM_CTR-1:0];
    assign clr_all = strb.ctrl && wdata[CTRL_ZERO_BIT];

    always_comb begin
        run_d = strb.ctrl ? wdata[CTRL_RUN_BIT] : run_q;

        en_d = en_q;
        if (strb.en_set) en_d = en_q | mask;
        if (strb.en_clr) en_d = en_q & ~mask;

        ie_d = ie_q;
        if (strb.ie_set) ie_d = ie_q | mask;
        if (strb.ie_clr) ie_d = ie_q & ~mask;

        // Clear first, then merge this cycle's overflows so they always win
        ovf_d = strb.ovf_clr ? (ovf_q & ~mask) : ovf_q;
        ovf_d = ovf_d | ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            en_q  <= '0;
            ie_q  <= '0;
            ovf_q <= '0;
            irq_q <= 1'b0;
        end else begin
            run_q <= run_d;
            en_q  <= en_d;
            ie_q  <= ie_d;
            ovf_q <= ovf_d;
            irq_q <= |(ovf_q & ie_q);
        end
    end

    assign run = run_q;
    assign en  = en_q;
    assign ie  = ie_q;
    assign ovf = ovf_q;
    assign irq = irq_q;

    // R4
    ovf_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (|ovf_evt) |=> ((ovf_q & $past(ovf_evt)) == $past(ovf_evt)));

    // R3
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ovf_q & ie_q)) |=> irq_q);

    // R3
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(ovf_q & ie_q)) |=> !irq_q);

    // R5
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.ovf_clr && ((mask & ovf_evt) == '0))
            |=> ((ovf_q & $past(mask)) == '0));

    // R6
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        strb.en_set |=> ((en_q & $past(mask)) == $past(mask)));

    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        strb.en_clr |=> ((en_q & $past(mask)) == '0));

endmodule

// File: rtl/pmu_ovf_unit.sv
module pmu_ovf_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] event_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);

    ctl_wr_t            strb;
    logic [NUM_CTR-1:0] ctr_hit;
    logic [NUM_CTR-1:0] inc;
    logic [NUM_CTR-1:0] ovf_evt;
    logic [NUM_CTR-1:0] en, ie, ovf;
    logic               run;
    logic               clr_all;
    logic [CTR_W-1:0]   cnt_arr [NUM_CTR];

    pmu_wr_decode #(.NUM_CTR(NUM_CTR)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strb    (strb),
        .ctr_hit (ctr_hit)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign inc[i] = event_i[i] && en[i] && run;

        pmu_counter #(.W(CTR_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .inc     (inc[i]),
            .wr_hit  (ctr_hit[i]),
            .clr_all (clr_all),
            .wdata   (wr_data[CTR_W-1:0]),
            .cnt     (cnt_arr[i]),
            .ovf_evt (ovf_evt[i])
        );
    end

    pmu_flags #(.NUM_CTR(NUM_CTR)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wdata   (wr_data),
        .ovf_evt (ovf_evt),
        .run     (run),
        .clr_all (clr_all),
        .en      (en),
        .ie      (ie),
        .ovf     (ovf),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:             rd_data[CTRL_RUN_BIT] = run;
            A_EN_SET, A_EN_CLR: rd_data = DATA_W'(en);
            A_IE_SET, A_IE_CLR: rd_data = DATA_W'(ie);
            A_OVF:              rd_data = DATA_W'(ovf);
            default: begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    if (rd_addr == ctr_addr(i)) rd_data = DATA_W'(cnt_arr[i]);
                end
            end
        endcase
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && (ovf == '0) && (en == '0) && !run));

endmodule

// File: tb/sim_pmu_ovf_unit.sv
`timescale 1ns/100ps
module sim_pmu_ovf_unit;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] ev = '0;
    logic        we = 1'b0;
    logic [5:0]  wa = '0;
    logic [31:0] wd = '0;
    logic [5:0]  ra = '0;
    logic [31:0] rd;
    logic        irq;

    always #4 clk = ~clk;

    pmu_ovf_unit #(.NUM_CTR(N), .CTR_W(32)) u0 (
        .clk(clk), .rst(rst), .event_i(ev), .wr_en(we), .wr_addr(wa),
        .wr_data(wd), .rd_addr(ra), .rd_data(rd), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_cnt [N];
    logic [N-1:0] m_en, m_ie, m_ovf;
    logic m_run, m_irq;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(logic [5:0] a);
        if (a == 0) return {31'b0, m_run};
        if (a == 1 || a == 2) return 32'(m_en);
        if (a == 3 || a == 4) return 32'(m_ie);
        if (a == 5) return 32'(m_ovf);
        if (a >= 8 && a < 8 + N) return m_cnt[a - 8];
        return 32'h0;
    endfunction

    function automatic string req_of(logic [5:0] a);
        if (a == 0) return "R8";
        if (a >= 1 && a <= 4) return "R6";
        if (a == 5) return "R5";
        if (a >= 8 && a < 8 + N) return "R1";
        return "R10";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_en = '0; m_ie = '0; m_ovf = '0; m_run = 0; m_irq = 0;
    endtask

    task automatic model_step(logic [N-1:0] e, logic w, logic [5:0] a, logic [31:0] d);
        logic [N-1:0] evt;
        logic zero;
        evt  = '0;
        zero = w && a == 0 && d[1];
        m_irq = |(m_ovf & m_ie);
        for (int i = 0; i < N; i++) begin
            logic go;
            go = e[i] && m_en[i] && m_run;
            if (w && a == 6'(8 + i)) m_cnt[i] = d;
            else begin
                if (go && m_cnt[i] == 32'hFFFF_FFFF) evt[i] = 1'b1;
                if (zero) m_cnt[i] = '0;
                else if (go) m_cnt[i] = m_cnt[i] + 1;
            end
        end
        if (w) begin
            case (a)
                6'd0: m_run = d[0];
                6'd1: m_en = m_en | d[N-1:0];
                6'd2: m_en = m_en & ~d[N-1:0];
                6'd3: m_ie = m_ie | d[N-1:0];
                6'd4: m_ie = m_ie & ~d[N-1:0];
                6'd5: m_ovf = m_ovf & ~d[N-1:0];
                default: ;
            endcase
        end
        m_ovf = m_ovf | evt;
    endtask

    task automatic compare_all();
        for (int a = 0; a < 16; a++) begin
            ra = 6'(a);
            #0.1;
            check(req_of(6'(a)), rd, m_read(6'(a)));
        end
        check("R3", {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic peek(logic [5:0] a, output logic [31:0] v);
        ra = a;
        #0.1;
        v = rd;
    endtask

    task automatic step(logic [N-1:0] e, logic w, logic [5:0] a, logic [31:0] d);
        ev = e; we = w; wa = a; wd = d;
        @(posedge clk);
        model_step(e, w, a, d);
        @(negedge clk);
        ev = '0; we = 1'b0;
        compare_all();
    endtask

    task automatic idle();
        step('0, 1'b0, 6'd0, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0] co_addr [9];
        logic [31:0] co_data [9];
        co_addr = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd12, 6'd63};
        co_data = '{32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1,
                    32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h5A5A_5A5A};

        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        peek(6'd0, v); check("R9", v, 32'h0);
        peek(6'd5, v); check("R9", v, 32'h0);
        peek(6'd8, v); check("R9", v, 32'h0);
        check("R9", {31'b0, irq}, 32'h0);
        compare_all();

        step('0, 1, 6'd0, 32'h1);
        step('0, 1, 6'd1, 32'hF);
        step('0, 1, 6'd3, 32'hF);
        // R7: load by write
        step('0, 1, 6'd8, 32'hFFFF_FFFE);
        peek(6'd8, v); check("R7", v, 32'hFFFF_FFFE);
        // R1: increment
        step(4'h1, 0, 6'd0, 0);
        peek(6'd8, v); check("R1", v, 32'hFFFF_FFFF);
        // R2: wrap and flag
        step(4'h1, 0, 6'd0, 0);
        peek(6'd8, v); check("R2", v, 32'h0);
        peek(6'd5, v); check("R2", v, 32'h1);
        check("R3", {31'b0, irq}, 32'h0);
        idle();
        check("R3", {31'b0, irq}, 32'h1);
        step('0, 1, 6'd5, 32'h1);
        peek(6'd5, v); check("R5", v, 32'h0);
        idle();
        check("R3", {31'b0, irq}, 32'h0);

        // R4: overflow colliding with every kind of non-counter write
        for (int k = 0; k < 9; k++) begin
            step('0, 1, 6'd8, 32'hFFFF_FFFF);
            step(4'h1, 1, co_addr[k], co_data[k]);
            peek(6'd5, v); check("R4", v & 32'h1, 32'h1);
            idle();
            check("R4", {31'b0, irq}, 32'h1);
            step('0, 1, 6'd5, 32'hF);
            idle();
        end

        // R8: bank zero with coincident overflow
        step('0, 1, 6'd9, 32'd123);
        step('0, 1, 6'd8, 32'hFFFF_FFFF);
        step(4'h1, 1, 6'd0, 32'h3);
        peek(6'd9, v); check("R8", v, 32'h0);
        peek(6'd5, v); check("R8", v, 32'h1);
        peek(6'd0, v); check("R8", v, 32'h1);
        step('0, 1, 6'd5, 32'hF);

        // R7: write beats the increment, no overflow recorded
        step('0, 1, 6'd8, 32'hFFFF_FFFF);
        step(4'h1, 1, 6'd8, 32'd5);
        peek(6'd8, v); check("R7", v, 32'd5);
        peek(6'd5, v); check("R7", v, 32'h0);

        // R6: set/clear pairs
        step('0, 1, 6'd1, 32'h0);
        peek(6'd2, v); check("R6", v, 32'hF);
        step('0, 1, 6'd2, 32'h2);
        peek(6'd1, v); check("R6", v, 32'hD);
        step('0, 1, 6'd4, 32'h1);
        peek(6'd3, v); check("R6", v, 32'hE);

        // R1: disabled counter and stopped bank hold
        step('0, 1, 6'd9, 32'd7);
        step(4'h2, 0, 6'd0, 0);
        peek(6'd9, v); check("R1", v, 32'd7);
        step('0, 1, 6'd0, 32'h0);
        step(4'hF, 0, 6'd0, 0);
        peek(6'd8, v); check("R1", v, 32'd5);

        // R10: unmapped write changes nothing
        step('0, 1, 6'd7, 32'hFFFF_FFFF);
        peek(6'd7, v); check("R10", v, 32'h0);
        peek(6'd1, v); check("R10", v, 32'hD);

        // Random phase with frequent collisions
        step('0, 1, 6'd0, 32'h1);
        step('0, 1, 6'd1, 32'hF);
        step('0, 1, 6'd3, 32'hF);
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] e;
            logic w;
            logic [5:0] a;
            logic [31:0] d;
            e = N'($urandom);
            w = ($urandom % 3) == 0;
            a = 6'($urandom % 16);
            d = $urandom;
            if (a >= 8 && a < 8 + N && ($urandom % 2) == 0)
                d = 32'hFFFF_FFF0 | ($urandom % 16);
            if (a == 0)
                d = {30'b0, (($urandom % 8) == 0), (($urandom % 6) != 0)};
            step(e, w, a, d);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule